// File: doc/BRIEF.md
# Receive FIFO Pause and DMA-Start Controller

This block sits beside a receive FIFO and watches how many bytes it holds. When the fill level climbs past a programmed high-water mark it asks the transmit MAC for a single XOFF PAUSE frame. When the level later drops below a programmed low-water mark it asks for a single XON frame. A one-bit paused state between the two marks gives hysteresis, so a level that hovers near one mark does not produce a stream of requests. Both marks are 9-bit counts of 64-byte units. They are packed into one threshold word: the XOFF mark sits in bits 8:0 and the XON mark in bits 20:12.

The same block decides when the FIFO holds enough data for the receive DMA engine to start moving it toward host memory. A 3-bit code picks the start level. A short frame that has fully arrived must not wait for that level, so a complete-frame indication also starts the transfer. Building the PAUSE frame and storing the data are done elsewhere.

Top module: `rx_pause_ctrl`

## Requirements
- R1: Reset clears the paused state and drives `xoff_req`, `xon_req` and `dma_start` low. After reset, a level below the XON mark gives no XON request, because the block is not paused.
- R2: While not paused, if `fifo_level` divided by 64 (integer) is strictly greater than `pause_thr[8:0]` at a clock edge, `xoff_req` is high for exactly the one cycle after that edge, and the block enters the paused state.
- R3: While paused, if `fifo_level` divided by 64 is strictly less than `pause_thr[20:12]` at a clock edge, `xon_req` is high for exactly the one cycle after that edge, and the block leaves the paused state.
- R4: No request repeats while the state is unchanged. A level held above the XOFF mark gives one XOFF pulse only. `xoff_req` and `xon_req` are never high together.
- R5: `dma_start` is high in the cycle after an edge where `fifo_level` is at least 64 shifted left by `dma_code`, for codes 0 to 5 (64, 128, 256, 512, 1024, 2048 bytes). Otherwise it is low, unless R6 applies.
- R6: `frame_ready` high at an edge makes `dma_start` high in the next cycle, whatever the level.
- R7: `dma_code` values 6 and 7 select the same 2048-byte start level as code 5.
- R8: The low 6 bits of `fifo_level` do not take part in the pause comparisons. A level of 64·T+63, with T equal to the XOFF mark, does not raise `xoff_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_level | input | OCC_W | Receive FIFO occupancy in bytes |
| pause_thr | input | ON_LSB+THR_W | XOFF mark in bits 8:0, XON mark in bits 20:12, both in 64-byte units |
| dma_code | input | 3 | DMA start level code |
| frame_ready | input | 1 | A complete frame is held in the FIFO |
| xoff_req | output | 1 | One-cycle request for an XOFF PAUSE frame |
| xon_req | output | 1 | One-cycle request for an XON PAUSE frame |
| dma_start | output | 1 | Enough data is present to begin the DMA transfer |

## Verification
Each of the three outputs is a register fed straight from the inputs. A change seen at one rising edge therefore shows up on `xoff_req`, `xon_req` or `dma_start` in the very next cycle. The bench drives its inputs on the falling edge and updates its behavioural model at the same rising edge as the design. It then compares all three outputs on the following falling edge, once per cycle, so every result is checked one cycle after its cause. Directed checks wait two cycles after a stimulus, so the expected pulse or level has already appeared before they count pulses or read `dma_start`.

// File: rtl/rx_pause_ctrl.sv
module rx_pause_ctrl #(
  parameter int OCC_W    = 14,
  parameter int UNIT_SH  = 6,
  parameter int THR_W    = 9,
  parameter int OFF_LSB  = 0,
  parameter int ON_LSB   = 12,
  parameter int CODE_W   = 3,
  parameter int CODE_MAX = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [OCC_W-1:0]          fifo_level,
  input  logic [ON_LSB+THR_W-1:0]   pause_thr,
  input  logic [CODE_W-1:0]         dma_code,
  input  logic                      frame_ready,
  output logic                      xoff_req,
  output logic                      xon_req,
  output logic                      dma_start
);

  localparam int UW = OCC_W - UNIT_SH;
  localparam int CW = (UW > THR_W) ? UW : THR_W;
  localparam int TOP_SH = UNIT_SH + CODE_MAX + 1;
  localparam int DW = (OCC_W > TOP_SH) ? OCC_W : TOP_SH;

  logic [CW-1:0]     units, off_mark, on_mark;
  logic [CODE_W-1:0] code_sat;
  logic [DW-1:0]     level_x, start_lvl;
  logic              paused, go_off, go_on;
  logic              unused_gap;

  assign unused_gap = ^pause_thr[ON_LSB-1:OFF_LSB+THR_W];

  assign units    = CW'(fifo_level[OCC_W-1:UNIT_SH]);
  assign off_mark = CW'(pause_thr[OFF_LSB +: THR_W]);
  assign on_mark  = CW'(pause_thr[ON_LSB +: THR_W]);

  assign go_off = !paused && (units > off_mark);
  assign go_on  =  paused && (units < on_mark);

  assign code_sat  = (dma_code > CODE_W'(CODE_MAX)) ? CODE_W'(CODE_MAX) : dma_code;
  assign start_lvl = DW'(1) << (UNIT_SH + int'(code_sat));
  assign level_x   = DW'(fifo_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paused    <= 1'b0;
      xoff_req  <= 1'b0;
      xon_req   <= 1'b0;
      dma_start <= 1'b0;
    end else begin
      xoff_req  <= go_off;
      xon_req   <= go_on;
      dma_start <= frame_ready || (level_x >= start_lvl);
      if (go_off)     paused <= 1'b1;
      else if (go_on) paused <= 1'b0;
    end
  end

  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(xoff_req && xon_req)); // R4
  AST_XOFF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_req |=> !xoff_req); // R4
  AST_XOFF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_req |-> (($past(fifo_level) >> UNIT_SH) > OCC_W'($past(pause_thr[OFF_LSB +: THR_W])))); // R2
  AST_XON_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    xon_req |-> (($past(fifo_level) >> UNIT_SH) < OCC_W'($past(pause_thr[ON_LSB +: THR_W])))); // R3
  AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready |=> dma_start); // R6
  AST_FULL_START: assert property (@(posedge clk) disable iff (!rst_n)
    (DW'(fifo_level) >= (DW'(1) << TOP_SH - 1)) |=> dma_start); // R7

endmodule

// File: tb/test_rx_pause_ctrl.sv
module test_rx_pause_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] fifo_level = '0;
  logic [20:0] pause_thr = '0;
  logic [2:0]  dma_code = '0;
  logic        frame_ready = 1'b0;
  logic        xoff_req, xon_req, dma_start;

  int tests = 0, fails = 0;
  int xoff_seen = 0, xon_seen = 0;
  int m_paused = 0, m_xoff = 0, m_xon = 0, m_dma = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_pause_ctrl i_rx_pause_ctrl (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .pause_thr(pause_thr),
    .dma_code(dma_code), .frame_ready(frame_ready),
    .xoff_req(xoff_req), .xon_req(xon_req), .dma_start(dma_start));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_paused = 0; m_xoff = 0; m_xon = 0; m_dma = 0;
    end else begin
      int u, thr;
      u = int'(fifo_level) / 64;
      m_xoff = (m_paused == 0 && u > int'(pause_thr[8:0])) ? 1 : 0;
      m_xon  = (m_paused == 1 && u < int'(pause_thr[20:12])) ? 1 : 0;
      if (m_xoff == 1) m_paused = 1;
      else if (m_xon == 1) m_paused = 0;
      thr = (dma_code > 3'd5) ? 2048 : (64 << dma_code);
      m_dma = (frame_ready || int'(fifo_level) >= thr) ? 1 : 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("R2 xoff_req vs model", int'(xoff_req), m_xoff);
    chk("R3 xon_req vs model", int'(xon_req), m_xon);
    chk("R5 dma_start vs model", int'(dma_start), m_dma);
    if (xoff_req) xoff_seen++;
    if (xon_req) xon_seen++;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    pause_thr = {9'd4, 3'd0, 9'd8};
    step(3);
    chk("R1 reset xoff_req", int'(xoff_req), 0);
    chk("R1 reset xon_req", int'(xon_req), 0);
    chk("R1 reset dma_start", int'(dma_start), 0);
    #1 rst_n = 1'b1;
    step(2);
    dma_code = 3'd7;
    fifo_level = 14'd575; step(5);
    chk("R8 low bits ignored for xoff", xoff_seen, 0);
    fifo_level = 14'd576; step(2);
    chk("R2 xoff pulse", xoff_seen, 1);
    step(6);
    chk("R4 xoff not repeated", xoff_seen, 1);
    chk("R4 no xon while held", xon_seen, 0);
    fifo_level = 14'd256; step(4);
    chk("R3 no xon at mark", xon_seen, 0);
    fifo_level = 14'd255; step(2);
    chk("R3 xon pulse", xon_seen, 1);
    step(4);
    chk("R4 xon not repeated", xon_seen, 1);
    fifo_level = 14'd700; step(2);
    chk("R4 second xoff after xon", xoff_seen, 2);
    for (int c = 0; c < 6; c++) begin
      dma_code = 3'(c);
      fifo_level = 14'((64 << c) - 1); step(2);
      chk("R5 below start level", int'(dma_start), 0);
      fifo_level = 14'(64 << c); step(2);
      chk("R5 at start level", int'(dma_start), 1);
    end
    for (int c = 6; c < 8; c++) begin
      dma_code = 3'(c);
      fifo_level = 14'd2047; step(2);
      chk("R7 saturated code below", int'(dma_start), 0);
      fifo_level = 14'd2048; step(2);
      chk("R7 saturated code at", int'(dma_start), 1);
    end
    dma_code = 3'd5; fifo_level = 14'd10; frame_ready = 1'b1; step(2);
    chk("R6 frame starts dma", int'(dma_start), 1);
    frame_ready = 1'b0; step(2);
    chk("R6 frame removed", int'(dma_start), 0);
    fifo_level = 14'd1000; step(2);
    xon_seen = 0;
    #1 rst_n = 1'b0;
    step(2);
    chk("R1 reset clears dma_start", int'(dma_start), 0);
    #1 rst_n = 1'b1;
    fifo_level = 14'd0; step(4);
    chk("R1 no xon after reset", xon_seen, 0);
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) pause_thr = {9'($urandom_range(0, 40)), 3'd0, 9'($urandom_range(0, 40))};
      fifo_level = 14'($urandom_range(0, 3000));
      dma_code = 3'($urandom_range(0, 7));
      frame_ready = ($urandom_range(0, 9) == 0);
      step(1);
    end
    step(2);
    summary();
  end
endmodule